// File: doc/BRIEF.md
# Double-Buffered Crosspoint Router

This block routes a set of single-bit data lanes. Each of its 68 external outputs, plus one internal output reserved for an activity monitor, carries exactly one of the 68 data inputs. Each output has a 7-bit route code, and that code picks its source. The data path is a plain multiplexer with no register in it, so any input reaches its outputs in the same cycle.

Route codes are kept in two stages. A write from the programming port lands in a per-output shadow register. A configure level then moves all shadow codes into the active registers at once. While that level is high, the active set follows the shadow set cycle by cycle. When it is low, the active set is frozen, so a whole new map can be staged and then switched in one step. The port accepts a write in three forms:
- Direct: the output number and the input number arrive on separate buses.
- Shared bus: the output number is captured first from the input-number bus, then the input number follows on the same bus.
- Page broadcast: one input number is written to every output marked in a 17-bit mask within a 2-bit page.

An init pin returns both register stages to straight-through routing. The load strobe, address-latch strobe, configure level and init pin are synchronized to the clock.

Top module: `xpoint_switch`

## Requirements
- R1: After reset, output i carries input i for i = 0..67, and the monitor output (output 68) carries input 0.
- R2: With serialMode=0, burstMode=0 and addrMuxed=0, a rising edge on loadPin while csN is low writes inId into the shadow code of output outId. A rising edge while csN is high writes nothing.
- R3: While cfgPin is high, the active codes follow the shadow codes. While cfgPin is low, shadow writes leave the routing unchanged until cfgPin is raised again.
- R4: With addrMuxed=1, a falling edge on alePin captures the output number from inId. The next accepted load writes the inId value present at that load to the captured output.
- R5: With burstMode=1 and serialMode=0, one load writes inId to every output numbered 17*pageSel + b for which outMask[b] is 1.
- R6: A route code from 68 to 127 drives the output to constant 0. A later write of a code from 0 to 67 routes the output again.
- R7: A pulse on initPin sets both the shadow and active codes to straight-through (output i from input i, monitor from input 0), whatever the cfgPin level.
- R8: A direct or shared-bus write to an output number from 69 to 127 changes no route.
- R9: The monitor output, number 68, can be written by the direct and shared-bus forms. Page broadcast reaches outputs 0..67 only.
- R10: While serialMode is 1, load edges write nothing, whatever the level of burstMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 68 | Data lanes in |
| dataOut | output | 68 | Routed data lanes out |
| monitorOut | output | 1 | Internal output 68, for the activity monitor |
| serialMode | input | 1 | 1 hands the port to the serial block, so loads are ignored here |
| burstMode | input | 1 | 1 selects the page broadcast form |
| addrMuxed | input | 1 | 1 takes the output number from the address latch |
| csN | input | 1 | Active-low select; a load needs it low |
| loadPin | input | 1 | Load strobe; the rising edge writes |
| alePin | input | 1 | Address-latch strobe; the falling edge captures inId |
| cfgPin | input | 1 | Configure level; high makes the active codes follow the shadow codes |
| initPin | input | 1 | Forces straight-through routing |
| inId | input | 7 | Input number, also the address in shared-bus form |
| outId | input | 7 | Output number for the direct form |
| pageSel | input | 2 | Page for broadcast |
| outMask | input | 17 | Output mask within the page |

## Verification
Routes are read back through the data path itself. The bench drives seven input patterns in which lane j carries bit b of j+1. The seven bits seen on each output then spell out its source number plus one, and a value of zero marks a disabled output. This tells a wrong source apart from a disabled output on all 69 outputs at once. The bench also sweeps every route code over one output, writes a distinct code to every output, and runs broadcast masks with sparse bits and with all bits set. These tell the decode of codes at the 67/68 boundary apart from the page decode, and show whether a change was staged or committed.

// File: rtl/xpoint_pkg.sv
package xpoint_pkg;
  localparam int SEL_W  = 7;
  localparam int PAGE_W = 2;
  localparam int MASK_W = 17;

  // Strobes handed from control to datapath, valid for one cycle
  typedef struct packed {
    logic              init;
    logic              commit;
    logic              wrValid;
    logic              burst;
    logic [PAGE_W-1:0] page;
    logic [MASK_W-1:0] mask;
    logic [SEL_W-1:0]  wrAddr;
    logic [SEL_W-1:0]  wrSel;
  } xpStrobe_t;
endpackage

// File: rtl/xpoint_sync.sv
module xpoint_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/xpoint_ctrl.sv
module xpoint_ctrl
  import xpoint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialMode,
  input  logic              burstMode,
  input  logic              addrMuxed,
  input  logic              csN,
  input  logic              loadPin,
  input  logic              alePin,
  input  logic              cfgPin,
  input  logic              initPin,
  input  logic [SEL_W-1:0]  inId,
  input  logic [SEL_W-1:0]  outId,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic [MASK_W-1:0] outMask,
  output xpStrobe_t         strb
);
  logic [3:0]       syncQ;
  logic             loadS, aleS, cfgS, initS;
  logic             loadPrev, alePrev;
  logic             loadRise, aleFall;
  logic [SEL_W-1:0] addrLatch;
  logic             parMode, bcastMode;

  xpoint_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({initPin, cfgPin, alePin, loadPin}),
    .syncOut(syncQ)
  );
  assign {initS, cfgS, aleS, loadS} = syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPrev  <= 1'b0;
      alePrev   <= 1'b0;
      addrLatch <= '0;
    end else begin
      loadPrev <= loadS;
      alePrev  <= aleS;
      if (aleFall) addrLatch <= inId;
    end
  end

  assign loadRise  = loadS & ~loadPrev;
  assign aleFall   = ~aleS & alePrev;
  assign parMode   = ~serialMode & ~burstMode;
  assign bcastMode = ~serialMode & burstMode;

  always_comb begin
    strb.init    = initS;
    strb.commit  = cfgS;
    strb.wrValid = loadRise & ~csN & (parMode | bcastMode);
    strb.burst   = bcastMode;
    strb.page    = pageSel;
    strb.mask    = outMask;
    strb.wrAddr  = addrMuxed ? addrLatch : outId;
    strb.wrSel   = inId;
  end

  // R2: one load edge yields a single write pulse
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrValid |=> !strb.wrValid);
endmodule

// File: rtl/xpoint_core.sv
module xpoint_core
  import xpoint_pkg::*;
#(
  parameter int NUM_IN  = 68,
  parameter int NUM_OUT = NUM_IN + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  xpStrobe_t          strb,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] yOut
);
  localparam logic [SEL_W-1:0] IN_LIMIT = SEL_W'(NUM_IN);
  localparam int               NUM_PAGE = 1 << PAGE_W;

  logic [NUM_OUT-1:0][SEL_W-1:0] shadowSel, activeSel, homeMap;
  logic [NUM_OUT-1:0]            wrHit, burstHit;

  for (genvar o = 0; o < NUM_OUT; o++) begin : gOut
    localparam int PG  = o / MASK_W;
    localparam int BIT = o % MASK_W;

    assign homeMap[o] = (o < NUM_IN) ? SEL_W'(o) : '0;

    if (o < NUM_IN && PG < NUM_PAGE) begin : gPaged
      assign burstHit[o] = (strb.page == PAGE_W'(PG)) && strb.mask[BIT];
    end else begin : gUnpaged
      assign burstHit[o] = 1'b0;
    end

    assign wrHit[o] = strb.wrValid &&
                      (strb.burst ? burstHit[o] : (strb.wrAddr == SEL_W'(o)));

    assign yOut[o] = (activeSel[o] < IN_LIMIT) ? dataIn[activeSel[o]] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowSel <= homeMap;
      activeSel <= homeMap;
    end else if (strb.init) begin
      shadowSel <= homeMap;
      activeSel <= homeMap;
    end else begin
      for (int o = 0; o < NUM_OUT; o++)
        if (wrHit[o]) shadowSel[o] <= strb.wrSel;
      if (strb.commit) activeSel <= shadowSel;
    end
  end

  assert_commit_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && !strb.init |=> activeSel == $past(shadowSel));

  assert_frozen_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit && !strb.init |=> $stable(activeSel));

  assert_init_home_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.init |=> (shadowSel == homeMap) && (activeSel == homeMap));

  assert_far_addr_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrValid && !strb.burst && !strb.init && (int'(strb.wrAddr) >= NUM_OUT)
    |=> $stable(shadowSel));
endmodule

// File: rtl/xpoint_switch.sv
module xpoint_switch
  import xpoint_pkg::*;
#(
  parameter int NUM_IN      = 68,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] dataIn,
  output logic [NUM_IN-1:0] dataOut,
  output logic              monitorOut,
  input  logic              serialMode,
  input  logic              burstMode,
  input  logic              addrMuxed,
  input  logic              csN,
  input  logic              loadPin,
  input  logic              alePin,
  input  logic              cfgPin,
  input  logic              initPin,
  input  logic [SEL_W-1:0]  inId,
  input  logic [SEL_W-1:0]  outId,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic [MASK_W-1:0] outMask
);
  localparam int NUM_OUT = NUM_IN + 1;

  xpStrobe_t          strb;
  logic [NUM_OUT-1:0] yAll;

  xpoint_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .serialMode(serialMode), .burstMode(burstMode), .addrMuxed(addrMuxed),
    .csN(csN), .loadPin(loadPin), .alePin(alePin), .cfgPin(cfgPin),
    .initPin(initPin), .inId(inId), .outId(outId), .pageSel(pageSel),
    .outMask(outMask), .strb(strb)
  );

  xpoint_core #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) uCore (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .yOut(yAll)
  );

  assign dataOut    = yAll[NUM_IN-1:0];
  assign monitorOut = yAll[NUM_IN];
endmodule

// File: tb/sim_xpoint_switch.sv
module sim_xpoint_switch;
  localparam int NI = 68;
  localparam int NO = 69;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NI-1:0] dataIn = '0;
  logic [NI-1:0] dataOut;
  logic monitorOut;
  logic serialMode = 0, burstMode = 0, addrMuxed = 0, csN = 0;
  logic loadPin = 0, alePin = 1, cfgPin = 0, initPin = 0;
  logic [6:0] inId = '0, outId = '0;
  logic [1:0] pageSel = '0;
  logic [16:0] outMask = '0;

  int checks = 0, errors = 0;
  int shadowM[NO];
  int activeM[NO];
  int got[NO];
  bit cfgM = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xpoint_switch u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataOut(dataOut),
    .monitorOut(monitorOut), .serialMode(serialMode), .burstMode(burstMode),
    .addrMuxed(addrMuxed), .csN(csN), .loadPin(loadPin), .alePin(alePin),
    .cfgPin(cfgPin), .initPin(initPin), .inId(inId), .outId(outId),
    .pageSel(pageSel), .outMask(outMask)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelHome();
    for (int o = 0; o < NO; o++) begin
      shadowM[o] = (o < NI) ? o : 0;
      activeM[o] = shadowM[o];
    end
  endtask

  task automatic mWrite(int o, int s);
    if (o < NO) begin
      shadowM[o] = s;
      if (cfgM) for (int k = 0; k < NO; k++) activeM[k] = shadowM[k];
    end
  endtask

  // Lane j carries bit b of j+1; seven passes rebuild every source number
  task automatic readRoutes();
    for (int o = 0; o < NO; o++) got[o] = 0;
    for (int b = 0; b < 7; b++) begin
      for (int j = 0; j < NI; j++) dataIn[j] = 1'(((j + 1) >> b) & 1);
      tick(1);
      for (int o = 0; o < NO; o++)
        if ((o < NI) ? dataOut[o] : monitorOut) got[o] |= (1 << b);
    end
    for (int o = 0; o < NO; o++) got[o] = (got[o] == 0) ? 127 : got[o] - 1;
  endtask

  function automatic int expSrc(int o);
    return (activeM[o] < NI) ? activeM[o] : 127;
  endfunction

  task automatic checkOne(int o, string req);
    checks++;
    if (got[o] != expSrc(o)) begin
      errors++;
      $display("FAIL %s output %0d source actual %0d expected %0d", req, o, got[o], expSrc(o));
    end
  endtask

  task automatic checkAll(string req);
    readRoutes();
    for (int o = 0; o < NO; o++) checkOne(o, req);
  endtask

  task automatic doLoad();
    loadPin = 1; tick(4);
    loadPin = 0; tick(4);
  endtask

  task automatic sepWrite(int o, int s, bit taken);
    outId = 7'(o); inId = 7'(s);
    doLoad();
    if (taken) mWrite(o, s);
  endtask

  task automatic muxWrite(int o, int s);
    addrMuxed = 1; inId = 7'(o);
    alePin = 1; tick(4);
    alePin = 0; tick(4);
    inId = 7'(s);
    doLoad();
    mWrite(o, s);
    alePin = 1; tick(4);
    addrMuxed = 0;
  endtask

  task automatic burstWrite(int p, int m, int s);
    burstMode = 1; tick(2);
    pageSel = 2'(p); outMask = 17'(m); inId = 7'(s);
    doLoad();
    for (int b = 0; b < 17; b++)
      if (((m >> b) & 1) != 0 && (p * 17 + b) < NI) mWrite(p * 17 + b, s);
    burstMode = 0; tick(2);
  endtask

  task automatic setCfg(bit v);
    cfgPin = v; tick(5);
    cfgM = v;
    if (v) for (int k = 0; k < NO; k++) activeM[k] = shadowM[k];
  endtask

  task automatic doInit();
    initPin = 1; tick(5);
    initPin = 0; tick(5);
    modelHome();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelHome();
    tick(3);
    rstN = 1;
    tick(4);
    checkAll("R1");

    setCfg(1);
    sepWrite(5, 20, 1);
    checkAll("R2");
    sepWrite(68, 33, 1);
    checkAll("R9");

    csN = 1;
    sepWrite(6, 1, 0);
    csN = 0;
    checkAll("R2");

    sepWrite(7, 127, 1);
    sepWrite(8, 100, 1);
    sepWrite(11, 68, 1);
    checkAll("R6");
    sepWrite(7, 3, 1);
    checkAll("R6");

    for (int s = 0; s < 128; s++) begin
      sepWrite(9, s, 1);
      readRoutes();
      checkOne(9, "R6");
    end

    sepWrite(80, 9, 0);
    sepWrite(127, 2, 0);
    sepWrite(69, 4, 0);
    checkAll("R8");

    for (int o = 0; o < NO; o++) sepWrite(o, (o * 37 + 11) % 70, 1);
    checkAll("R2");

    setCfg(0);
    sepWrite(0, 40, 1);
    sepWrite(67, 1, 1);
    muxWrite(12, 13);
    checkAll("R3");
    setCfg(1);
    checkAll("R3");

    muxWrite(10, 50);
    muxWrite(68, 2);
    checkAll("R4");
    muxWrite(200 % 128, 5);
    checkAll("R9");

    burstWrite(2, 17'h10005, 60);
    checkAll("R5");
    burstWrite(3, 17'h1FFFF, 12);
    checkAll("R5");
    burstWrite(0, 17'h00001, 127);
    checkAll("R5");

    serialMode = 1; tick(2);
    sepWrite(3, 44, 0);
    burstMode = 1; tick(2);
    pageSel = 0; outMask = 17'h1FFFF; inId = 7'd9;
    doLoad();
    burstMode = 0; serialMode = 0; tick(2);
    checkAll("R10");

    setCfg(0);
    sepWrite(20, 21, 1);
    doInit();
    checkAll("R7");
    setCfg(1);
    checkAll("R7");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule